// File: doc/BRIEF.md
# Ternary Two-Pair Rail Checker

This block combines the check signals of two ternary self-testing cells into a single check pair that can be chained. Each cell reports a pair of trits in which the second trit should be the first trit plus one, modulo three. The checker takes two such pairs and produces two output trits. The second output is the modular successor of the first only when both incoming pairs are valid.

The two outputs come from two separate comparator paths. The first path compares the first pair and marks a good result with trit 1. The second path compares the second pair and marks a good result with trit 2. Either path outputs trit 0 when its pair is bad. A good result from both paths is therefore the pair (1, 2), which is itself a valid successor pair. This lets several checkers form a tree. Because the two outputs come from separate logic, a single internal fault can corrupt only one of them.

Each path has a fault-injection override that replaces its comparator result with a chosen value, so the detection property can be exercised. A pass flag summarises whether the output pair is a successor pair. The parameter `REG_OUT` chooses between a registered output stage and a purely combinational one.

Top module: `tpr_rail_checker`

## Requirements
- R1: With `REG_OUT`=1, while `rst_n` is low, `x3_o` and `x4_o` read trit 0 from the clock edge after reset is seen, and `pass_o` reads 0.
- R2: Trits are coded 0=2'b00, 1=2'b01, 2=2'b10. With no injection, `x3_o` is trit 1 when `y0_i` equals (`x0_i`+1) mod 3, and trit 0 otherwise.
- R3: With no injection, `x4_o` is trit 2 when `y1_i` equals (`x1_i`+1) mod 3, and trit 0 otherwise.
- R4: The code 2'b11 on any of the four pair inputs makes that pair fail, so its comparator outputs trit 0.
- R5: `pass_o` is 1 exactly when `x4_o` is a valid trit equal to (`x3_o`+1) mod 3 and `x3_o` is a valid trit. With no injection, this happens only when both pairs are good.
- R6: When `inj_a_en_i` is high, `x3_o` takes the value of `inj_a_val_i`, which may be any 2-bit code. `x4_o` is unchanged.
- R7: When `inj_b_en_i` is high, `x4_o` takes the value of `inj_b_val_i`, which may be any 2-bit code. `x3_o` is unchanged.
- R8: With `REG_OUT`=1, outputs reflect the inputs sampled at the previous rising clock edge. With `REG_OUT`=0, they follow the inputs in the same cycle.
- R9: A good output pair (1, 2), fed back as the first input pair of a checker, counts as a good pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| x0_i | input | 2 | First trit of pair A |
| y0_i | input | 2 | Second trit of pair A, expected to be x0_i plus one |
| x1_i | input | 2 | First trit of pair B |
| y1_i | input | 2 | Second trit of pair B, expected to be x1_i plus one |
| inj_a_en_i | input | 1 | Replace the path-A result with inj_a_val_i |
| inj_a_val_i | input | 2 | Forced value for path A |
| inj_b_en_i | input | 1 | Replace the path-B result with inj_b_val_i |
| inj_b_val_i | input | 2 | Forced value for path B |
| x3_o | output | 2 | Check output from path A (1 when good, 0 when bad) |
| x4_o | output | 2 | Check output from path B (2 when good, 0 when bad) |
| pass_o | output | 1 | Output pair forms a successor pair |

## Verification
The bench builds two instances side by side. One uses `REG_OUT`=1, which brings the reset value and the one-cycle output latency within reach. The other uses `REG_OUT`=0, which exposes the comparator results in the same cycle as the inputs that cause them. Both instances see every one of the 256 raw input code combinations, so the 81 valid trit combinations and every combination with an illegal code are covered. A table of directed vectors drives single and double fault injection. A chained step feeds the good output pair back in as a new input pair.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    localparam int TRIT_W = 2;

    typedef logic [TRIT_W-1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_ONE  = 2'b01;
    localparam trit_t T_TWO  = 2'b10;
    localparam trit_t T_BAD  = 2'b11;

    // modular increment; an illegal code maps to the illegal code
    function automatic trit_t trit_inc(trit_t a);
        trit_t r;
        unique case (a)
            T_ZERO:  r = T_ONE;
            T_ONE:   r = T_TWO;
            T_TWO:   r = T_ZERO;
            default: r = T_BAD;
        endcase
        return r;
    endfunction

    // true when b is the legal successor of a legal a
    function automatic logic trit_follows(trit_t a, trit_t b);
        return (a != T_BAD) && (b != T_BAD) && (b == trit_inc(a));
    endfunction

endpackage

// File: rtl/tpr_cmp_elem.sv
module tpr_cmp_elem
    import tpr_pkg::*;
#(
    parameter trit_t MARK = T_ONE
) (
    input  trit_t lo_i,
    input  trit_t hi_i,
    output trit_t k_o
);

    // constant zero line, shifted to MARK only on a good pair
    always_comb begin
        if (trit_follows(lo_i, hi_i)) begin
            k_o = MARK;
        end else begin
            k_o = T_ZERO;
        end
    end

endmodule

// File: rtl/tpr_fault_ovr.sv
module tpr_fault_ovr
    import tpr_pkg::*;
(
    input  trit_t k_i,
    input  logic  en_i,
    input  trit_t val_i,
    output trit_t k_o
);

    always_comb begin
        k_o = en_i ? val_i : k_i;
    end

endmodule

// File: rtl/tpr_out_stage.sv
module tpr_out_stage
    import tpr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  trit_t a_i,
    input  trit_t b_i,
    output trit_t a_o,
    output trit_t b_o
);

    generate
        if (REG_OUT) begin : g_reg
            trit_t a_q;
            trit_t b_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    a_q <= T_ZERO;
                    b_q <= T_ZERO;
                end else begin
                    a_q <= a_i;
                    b_q <= b_i;
                end
            end
            assign a_o = a_q;
            assign b_o = b_q;
        end else begin : g_comb
            assign a_o = a_i;
            assign b_o = b_i;
        end
    endgenerate

endmodule

// File: rtl/tpr_rail_checker.sv
module tpr_rail_checker
    import tpr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] x0_i,
    input  logic [1:0] y0_i,
    input  logic [1:0] x1_i,
    input  logic [1:0] y1_i,
    input  logic       inj_a_en_i,
    input  logic [1:0] inj_a_val_i,
    input  logic       inj_b_en_i,
    input  logic [1:0] inj_b_val_i,
    output logic [1:0] x3_o,
    output logic [1:0] x4_o,
    output logic       pass_o
);

    trit_t cmp_a;
    trit_t cmp_b;
    trit_t ovr_a;
    trit_t ovr_b;

    // path A: separate comparator, marks a good pair with 1
    tpr_cmp_elem #(.MARK(T_ONE)) u_cmp_a (
        .lo_i (x0_i),
        .hi_i (y0_i),
        .k_o  (cmp_a)
    );

    // path B: separate comparator, marks a good pair with 2
    tpr_cmp_elem #(.MARK(T_TWO)) u_cmp_b (
        .lo_i (x1_i),
        .hi_i (y1_i),
        .k_o  (cmp_b)
    );

    tpr_fault_ovr u_ovr_a (
        .k_i   (cmp_a),
        .en_i  (inj_a_en_i),
        .val_i (inj_a_val_i),
        .k_o   (ovr_a)
    );

    tpr_fault_ovr u_ovr_b (
        .k_i   (cmp_b),
        .en_i  (inj_b_en_i),
        .val_i (inj_b_val_i),
        .k_o   (ovr_b)
    );

    tpr_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (ovr_a),
        .b_i   (ovr_b),
        .a_o   (x3_o),
        .b_o   (x4_o)
    );

    // debug summary taken from the outputs themselves
    always_comb begin
        pass_o = trit_follows(x3_o, x4_o);
    end

endmodule

// File: rtl/tpr_rail_checker_sva.sv
module tpr_rail_checker_sva
    import tpr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] x0_i,
    input logic [1:0] y0_i,
    input logic [1:0] x1_i,
    input logic [1:0] y1_i,
    input logic       inj_a_en_i,
    input logic [1:0] inj_a_val_i,
    input logic       inj_b_en_i,
    input logic [1:0] inj_b_val_i,
    input logic [1:0] x3_o,
    input logic [1:0] x4_o,
    input logic       pass_o
);

    logic good_a;
    logic good_b;
    assign good_a = trit_follows(x0_i, y0_i);
    assign good_b = trit_follows(x1_i, y1_i);

    generate
        if (REG_OUT) begin : g_seq
            // R1 and R8
            a_r1_reset_zero: assert property (@(posedge clk)
                !rst_n |=> (x3_o == T_ZERO && x4_o == T_ZERO && !pass_o));
            // R2 and R8
            a_r2_a_good: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_a_en_i && good_a) |=> (x3_o == T_ONE));
            // R2 and R4
            a_r4_a_bad: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_a_en_i && !good_a) |=> (x3_o == T_ZERO));
            // R3
            a_r3_b_good: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_b_en_i && good_b) |=> (x4_o == T_TWO));
            a_r3_b_bad: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_b_en_i && !good_b) |=> (x4_o == T_ZERO));
            // R5
            a_r5_pass_iff_both: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_a_en_i && !inj_b_en_i) |=> (pass_o == $past(good_a && good_b)));
            // R6
            a_r6_force_a: assert property (@(posedge clk) disable iff (!rst_n)
                inj_a_en_i |=> (x3_o == $past(inj_a_val_i)));
            // R7
            a_r7_force_b: assert property (@(posedge clk) disable iff (!rst_n)
                inj_b_en_i |=> (x4_o == $past(inj_b_val_i)));
        end else begin : g_comb
            a_r2_a_good: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_a_en_i && good_a) |-> (x3_o == T_ONE));
            a_r4_a_bad: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_a_en_i && !good_a) |-> (x3_o == T_ZERO));
            a_r3_b_good: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_b_en_i && good_b) |-> (x4_o == T_TWO));
            a_r5_pass_iff_both: assert property (@(posedge clk) disable iff (!rst_n)
                (!inj_a_en_i && !inj_b_en_i) |-> (pass_o == (good_a && good_b)));
            a_r6_force_a: assert property (@(posedge clk) disable iff (!rst_n)
                inj_a_en_i |-> (x3_o == inj_a_val_i));
            a_r7_force_b: assert property (@(posedge clk) disable iff (!rst_n)
                inj_b_en_i |-> (x4_o == inj_b_val_i));
        end
    endgenerate

endmodule

bind tpr_rail_checker tpr_rail_checker_sva #(.REG_OUT(REG_OUT)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .x0_i        (x0_i),
    .y0_i        (y0_i),
    .x1_i        (x1_i),
    .y1_i        (y1_i),
    .inj_a_en_i  (inj_a_en_i),
    .inj_a_val_i (inj_a_val_i),
    .inj_b_en_i  (inj_b_en_i),
    .inj_b_val_i (inj_b_val_i),
    .x3_o        (x3_o),
    .x4_o        (x4_o),
    .pass_o      (pass_o)
);

// File: tb/tpr_rail_checker_tb_top.sv
`timescale 1ns/1ps
module tpr_rail_checker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] x0, y0, x1, y1;
    logic       ia_en, ib_en;
    logic [1:0] ia_v, ib_v;
    logic [1:0] r_x3, r_x4, c_x3, c_x4;
    logic       r_pass, c_pass;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tpr_rail_checker #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .x0_i(x0), .y0_i(y0), .x1_i(x1), .y1_i(y1),
        .inj_a_en_i(ia_en), .inj_a_val_i(ia_v),
        .inj_b_en_i(ib_en), .inj_b_val_i(ib_v),
        .x3_o(r_x3), .x4_o(r_x4), .pass_o(r_pass)
    );

    tpr_rail_checker #(.REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n),
        .x0_i(x0), .y0_i(y0), .x1_i(x1), .y1_i(y1),
        .inj_a_en_i(ia_en), .inj_a_val_i(ia_v),
        .inj_b_en_i(ib_en), .inj_b_val_i(ib_v),
        .x3_o(c_x3), .x4_o(c_x4), .pass_o(c_pass)
    );

    // {x0,y0,x1,y1,ia_en,ia_v,ib_en,ib_v,exp_x3,exp_x4,exp_pass}
    localparam int NTBL = 10;
    localparam logic [18:0] TBL [NTBL] = '{
        {2'd0,2'd1,2'd2,2'd0, 1'b0,2'd0, 1'b0,2'd0, 2'd1,2'd2,1'b1}, // R2 R3 R5
        {2'd2,2'd0,2'd0,2'd0, 1'b0,2'd0, 1'b0,2'd0, 2'd1,2'd0,1'b0}, // R3 R5
        {2'd1,2'd1,2'd1,2'd2, 1'b0,2'd0, 1'b0,2'd0, 2'd0,2'd2,1'b0}, // R2 R5
        {2'd1,2'd2,2'd1,2'd2, 1'b1,2'd0, 1'b0,2'd0, 2'd0,2'd2,1'b0}, // R6
        {2'd1,2'd2,2'd1,2'd2, 1'b0,2'd0, 1'b1,2'd0, 2'd1,2'd0,1'b0}, // R7
        {2'd1,2'd2,2'd1,2'd2, 1'b1,2'd3, 1'b0,2'd0, 2'd3,2'd2,1'b0}, // R6 R5
        {2'd3,2'd0,2'd0,2'd1, 1'b0,2'd0, 1'b0,2'd0, 2'd0,2'd2,1'b0}, // R4
        {2'd0,2'd1,2'd2,2'd3, 1'b0,2'd0, 1'b0,2'd0, 2'd1,2'd0,1'b0}, // R4
        {2'd0,2'd0,2'd0,2'd1, 1'b1,2'd1, 1'b0,2'd0, 2'd1,2'd2,1'b1}, // R6 R5
        {2'd0,2'd0,2'd0,2'd0, 1'b1,2'd2, 1'b1,2'd0, 2'd2,2'd0,1'b1}  // R6 R7 R5
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ok_pair(input int a, input int b);
        if (a > 2 || b > 2) return 0;
        return (b == (a + 1) % 3) ? 1 : 0;
    endfunction

    function automatic int pass_of(input int a, input int b);
        return ok_pair(a, b);
    endfunction

    // drive at the falling edge, check both instances at the right times
    task automatic apply(input logic [1:0] a0, input logic [1:0] b0,
                         input logic [1:0] a1, input logic [1:0] b1,
                         input logic e_a, input logic [1:0] v_a,
                         input logic e_b, input logic [1:0] v_b,
                         input int e3, input int e4, input int ep, input string req);
        @(negedge clk);
        x0 = a0; y0 = b0; x1 = a1; y1 = b1;
        ia_en = e_a; ia_v = v_a; ib_en = e_b; ib_v = v_b;
        #1;
        chk({req, " R8"}, "comb x3", int'(c_x3), e3);
        chk({req, " R8"}, "comb x4", int'(c_x4), e4);
        chk({req, " R5"}, "comb pass", int'(c_pass), ep);
        @(posedge clk);
        #1;
        chk({req, " R8"}, "reg x3", int'(r_x3), e3);
        chk({req, " R8"}, "reg x4", int'(r_x4), e4);
        chk({req, " R5"}, "reg pass", int'(r_pass), ep);
    endtask

    initial begin
        #(20000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        x0 = 2'd0; y0 = 2'd1; x1 = 2'd2; y1 = 2'd0;
        ia_en = 1'b0; ia_v = 2'd0; ib_en = 1'b0; ib_v = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        // R1: good pairs presented, but reset holds the registered outputs at zero
        chk("R1", "reset x3", int'(r_x3), 0);
        chk("R1", "reset x4", int'(r_x4), 0);
        chk("R1", "reset pass", int'(r_pass), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed table
        for (int i = 0; i < NTBL; i++) begin
            logic [18:0] v;
            v = TBL[i];
            apply(v[18:17], v[16:15], v[14:13], v[12:11],
                  v[10], v[9:8], v[7], v[6:5],
                  int'(v[4:3]), int'(v[2:1]), int'(v[0]), "R6/R7 table");
        end

        // exhaustive raw codes: R2 R3 R4 R5
        for (int c = 0; c < 256; c++) begin
            logic [7:0] w;
            int e3, e4;
            w = c[7:0];
            e3 = ok_pair(int'(w[7:6]), int'(w[5:4])) ? 1 : 0;
            e4 = ok_pair(int'(w[3:2]), int'(w[1:0])) ? 2 : 0;
            apply(w[7:6], w[5:4], w[3:2], w[1:0], 1'b0, 2'd0, 1'b0, 2'd0,
                  e3, e4, pass_of(e3, e4), "R2 R3 R4");
        end

        // R9: chain the good output pair back in as pair A
        apply(2'd2, 2'd0, 2'd1, 2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 1, 2, 1, "R9 src");
        apply(c_x3, c_x4, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 1, 2, 1, "R9 chain");

        // R1 again: reset reasserted mid-run clears the registered stage
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "re-reset x3", int'(r_x3), 0);
        chk("R1", "re-reset x4", int'(r_x4), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule